// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive byte stream of an Ethernet MAC. It watches the first six bytes of each frame, the destination address, and decides whether the frame is kept. It also reports a miss flag for the receive descriptor. The destination is classified in a fixed priority order. An all-ones address is handled as broadcast. Otherwise a group address, or any address when the hash-all mode is on, is looked up in a 64-entry hash table indexed by CRC bits. Every remaining address is compared against the station address held in two 32-bit registers. Promiscuous mode then turns every miss into an accepted frame, but the miss flag is still reported.

The byte stream uses valid/ready with a start-of-frame and an end-of-frame marker. A byte moves on every cycle in which `in_valid` and `in_ready` are both high. The filter never applies back-pressure: `in_ready` is always high, so an upstream source may present a byte on any cycle and may insert idle cycles anywhere. `in_sof` and `in_last` have meaning only on a cycle in which a byte moves. The CRC is built serially, one byte per transfer, so no address buffer is needed. The verdict is registered and held until the next frame starts.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset, `res_valid`, `res_accept` and `res_miss` are low. `in_ready` is high at all times.
- R2: A destination whose six bytes are all 0xFF is broadcast. This class takes priority over the group bit. For broadcast, `res_miss` equals `cfg_bcast_reject`.
- R3: The hash table is used when the destination is not broadcast and either bit 0 of destination byte 0 is 1 or `cfg_hash_all` is 1. The index is found as follows.
  - A 32-bit CRC register starts at all ones.
  - Each byte is fed LSB first.
  - For each bit, the register shifts left and XORs 0x04C11DB7 when its old bit 31 differs from the data bit.
  - There is no final inversion.
  - The index is bits 31:26 of the register after the sixth byte.
  - Table entry n is `hash_lo[n]` for n < 32 and `hash_hi[n-32]` otherwise.
  - A zero entry is a miss.
- R4: Every other destination is compared with the station address, and any differing byte is a miss. The byte positions are:
  - Byte 0 is `stn_addr_hi[15:8]` and byte 1 is `stn_addr_hi[7:0]`.
  - Bytes 2 to 5 are `stn_addr_lo[31:24]`, `[23:16]`, `[15:8]` and `[7:0]`.
  - `stn_addr_hi[31:16]` is unused.
- R5: `res_accept` equals (not miss) or `cfg_promisc`. `res_miss` is reported even when the frame is accepted through promiscuous mode.
- R6: A frame whose `in_last` byte arrives before its sixth byte skips classification. Its result is miss=1 and accept=`cfg_promisc`, valid in the cycle after that last byte moves. This includes a one-byte frame.
- R7: The result becomes valid in the cycle after the sixth destination byte moves, and `res_valid` is low before that within the frame. Idle cycles between bytes do not change this, and bytes after the sixth have no effect.
- R8: A verdict and its `res_valid` hold until the next start-of-frame transfer. Changes to the configuration inputs after the decision do not alter it. A start-of-frame transfer that does not also end the frame clears `res_valid` in the following cycle.
- R9: The following are ignored:
  - Byte transfers after `in_last` and before the next `in_sof`.
  - `in_sof` while `in_valid` is low.
  
  A start-of-frame in the middle of a frame restarts classification from that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A receive byte is presented |
| in_ready | output | 1 | Filter takes the byte (always high) |
| in_data | input | 8 | Receive byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_last | input | 1 | Byte is the last of a frame |
| cfg_bcast_reject | input | 1 | Broadcast frames count as misses |
| cfg_hash_all | input | 1 | Send every non-broadcast address through the hash table |
| cfg_promisc | input | 1 | Accept frames that miss |
| hash_lo | input | 32 | Hash table entries 0 to 31 |
| hash_hi | input | 32 | Hash table entries 32 to 63 |
| stn_addr_hi | input | 32 | Station address bytes 0 and 1 in bits 15:0 |
| stn_addr_lo | input | 32 | Station address bytes 2 to 5 |
| res_valid | output | 1 | Verdict for the current frame is available |
| res_accept | output | 1 | Frame is kept |
| res_miss | output | 1 | Descriptor miss flag |

## Verification
The bench builds the filter with its default parameters: six address bytes, 8-bit data, 32-bit registers and a 6-bit hash index. Under these values every one of the 64 table entries can be reached through its own CRC index. The bench computes that index with a reflected shift register, which is a different formulation from the one in the design. With the defaults, the sixth-byte boundary lies inside frames of 4 to 9 bytes. This puts short frames, exact-length frames and frames with trailing bytes in the same vector walk, along with idle gaps between bytes.

// File: rtl/rxdf_pkg.sv
package rxdf_pkg;
  localparam int unsigned CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFF_FFFF;

  typedef enum logic [1:0] {
    CLS_SHORT   = 2'd0,
    CLS_BCAST   = 2'd1,
    CLS_GROUP   = 2'd2,
    CLS_STATION = 2'd3
  } dest_class_e;
endpackage

// File: rtl/rxdf_beat_tracker.sv
module rxdf_beat_tracker #(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned IDX_W = $clog2(ADDR_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_i,
  input  logic             sof_i,
  input  logic             last_i,
  output logic             examine_o,
  output logic             first_o,
  output logic             eval_o,
  output logic             short_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] END_IDX = IDX_W'(ADDR_BYTES - 1);
  localparam logic [IDX_W-1:0] FULL    = IDX_W'(ADDR_BYTES);

  logic [IDX_W-1:0] seen_q;
  logic             live_q;
  logic             at_end;

  always_comb begin
    first_o   = beat_i & sof_i;
    examine_o = first_o | (beat_i & live_q & (seen_q < FULL));
    idx_o     = first_o ? '0 : seen_q;
    at_end    = (idx_o == END_IDX);
    eval_o    = examine_o & (at_end | last_i);
    short_o   = ~at_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
      live_q <= 1'b0;
    end else if (first_o) begin
      live_q <= ~last_i;
      seen_q <= IDX_W'(1);
    end else if (beat_i & live_q) begin
      if (last_i) live_q <= 1'b0;
      if (examine_o) seen_q <= seen_q + 1'b1;
    end
  end

  // R7
  single_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eval_o |=> !(eval_o && !first_o));
endmodule

// File: rtl/rxdf_crc_step.sv
module rxdf_crc_step #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CRC_W = 32,
  parameter logic [CRC_W-1:0] POLY = 32'h04C1_1DB7,
  parameter logic [CRC_W-1:0] SEED = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              restart_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_next_o
);
  logic [CRC_W-1:0] crc_q;

  always_comb begin
    logic [CRC_W-1:0] c;
    c = restart_i ? SEED : crc_q;
    for (int b = 0; b < int'(DATA_W); b++) begin
      if (c[CRC_W-1] ^ data_i[b]) c = {c[CRC_W-2:0], 1'b0} ^ POLY;
      else                        c = {c[CRC_W-2:0], 1'b0};
    end
    crc_next_o = c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= SEED;
    else if (load_i) crc_q <= crc_next_o;
  end
endmodule

// File: rtl/rxdf_dest_match.sv
module rxdf_dest_match #(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned REG_W = 32,
  parameter int unsigned IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              examine_i,
  input  logic              first_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [REG_W-1:0]  stn_hi_i,
  input  logic [REG_W-1:0]  stn_lo_i,
  output logic              ones_o,
  output logic              match_o,
  output logic              group_o
);
  localparam int unsigned LO_BYTES = REG_W / DATA_W;
  localparam int unsigned HI_BYTES = ADDR_BYTES - LO_BYTES;

  logic [DATA_W-1:0] stn_byte [ADDR_BYTES];
  logic [DATA_W-1:0] want_byte;
  logic ones_q, match_q, group_q;

  for (genvar i = 0; i < int'(ADDR_BYTES); i++) begin : g_lane
    if (i < int'(HI_BYTES)) begin : g_hi
      assign stn_byte[i] = stn_hi_i[(int'(HI_BYTES) - 1 - i) * int'(DATA_W) +: DATA_W];
    end else begin : g_lo
      assign stn_byte[i] = stn_lo_i[(int'(ADDR_BYTES) - 1 - i) * int'(DATA_W) +: DATA_W];
    end
  end

  always_comb begin
    want_byte = '0;
    for (int k = 0; k < int'(ADDR_BYTES); k++) begin
      if (idx_i == IDX_W'(k)) want_byte = stn_byte[k];
    end
    ones_o  = (first_i | ones_q) & (data_i == {DATA_W{1'b1}});
    match_o = (first_i | match_q) & (data_i == want_byte);
    group_o = first_i ? data_i[0] : group_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q  <= 1'b0;
      match_q <= 1'b0;
      group_q <= 1'b0;
    end else if (examine_i) begin
      ones_q  <= ones_o;
      match_q <= match_o;
      group_q <= group_o;
    end
  end

  // R2
  bcast_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ones_q) |-> $past(first_i));
  // R4
  station_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_q) |-> $past(first_i));
endmodule

// File: rtl/rxdf_verdict.sv
module rxdf_verdict
  import rxdf_pkg::*;
#(
  parameter int unsigned HASH_IDX_W = 6,
  parameter int unsigned REG_W = 32,
  parameter int unsigned CRC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             first_i,
  input  logic             eval_i,
  input  logic             short_i,
  input  logic             ones_i,
  input  logic             match_i,
  input  logic             group_i,
  input  logic [CRC_W-1:0] crc_i,
  input  logic             bcast_reject_i,
  input  logic             hash_all_i,
  input  logic             promisc_i,
  input  logic [REG_W-1:0] hash_lo_i,
  input  logic [REG_W-1:0] hash_hi_i,
  output logic             valid_o,
  output logic             accept_o,
  output logic             miss_o
);
  localparam int unsigned TBL_BITS = 2 * REG_W;

  logic [TBL_BITS-1:0]   tbl;
  logic [HASH_IDX_W-1:0] hidx;
  logic                  hit;
  dest_class_e           cls;
  logic                  miss_d;

  always_comb begin
    tbl  = {hash_hi_i, hash_lo_i};
    hidx = crc_i[CRC_W-1 -: HASH_IDX_W];
    hit  = tbl[hidx];
    if (short_i)                   cls = CLS_SHORT;
    else if (ones_i)               cls = CLS_BCAST;
    else if (group_i | hash_all_i) cls = CLS_GROUP;
    else                           cls = CLS_STATION;
    case (cls)
      CLS_SHORT: miss_d = 1'b1;
      CLS_BCAST: miss_d = bcast_reject_i;
      CLS_GROUP: miss_d = ~hit;
      default:   miss_d = ~match_i;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o  <= 1'b0;
      accept_o <= 1'b0;
      miss_o   <= 1'b0;
    end else if (eval_i) begin
      valid_o  <= 1'b1;
      accept_o <= ~miss_d | promisc_i;
      miss_o   <= miss_d;
    end else if (first_i) begin
      valid_o <= 1'b0;
    end
  end

  // R8
  hold_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !first_i) |=> (valid_o && $stable(accept_o) && $stable(miss_o)));
  // R8
  sof_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (first_i && !eval_i) |=> !valid_o);
  // R5
  promisc_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && promisc_i) |=> accept_o);
  // R6
  short_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && short_i) |=> (miss_o && valid_o));
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import rxdf_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned REG_W = 32,
  parameter int unsigned HASH_IDX_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_last,
  input  logic              cfg_bcast_reject,
  input  logic              cfg_hash_all,
  input  logic              cfg_promisc,
  input  logic [REG_W-1:0]  hash_lo,
  input  logic [REG_W-1:0]  hash_hi,
  input  logic [REG_W-1:0]  stn_addr_hi,
  input  logic [REG_W-1:0]  stn_addr_lo,
  output logic              res_valid,
  output logic              res_accept,
  output logic              res_miss
);
  localparam int unsigned IDX_W = $clog2(ADDR_BYTES + 1);

  logic             beat, examine, first, eval, short_f;
  logic [IDX_W-1:0] idx;
  logic [CRC_W-1:0] crc_next;
  logic             ones, match, group;

  assign in_ready = 1'b1;
  assign beat     = in_valid & in_ready;

  rxdf_beat_tracker #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(IDX_W)) trk_i (
    .clk(clk), .rst_n(rst_n), .beat_i(beat), .sof_i(in_sof), .last_i(in_last),
    .examine_o(examine), .first_o(first), .eval_o(eval), .short_o(short_f),
    .idx_o(idx));

  rxdf_crc_step #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(CRC_POLY), .SEED(CRC_SEED)) crc_i (
    .clk(clk), .rst_n(rst_n), .load_i(examine), .restart_i(first),
    .data_i(in_data), .crc_next_o(crc_next));

  rxdf_dest_match #(.ADDR_BYTES(ADDR_BYTES), .DATA_W(DATA_W), .REG_W(REG_W),
                    .IDX_W(IDX_W)) cmp_i (
    .clk(clk), .rst_n(rst_n), .examine_i(examine), .first_i(first), .idx_i(idx),
    .data_i(in_data), .stn_hi_i(stn_addr_hi), .stn_lo_i(stn_addr_lo),
    .ones_o(ones), .match_o(match), .group_o(group));

  rxdf_verdict #(.HASH_IDX_W(HASH_IDX_W), .REG_W(REG_W), .CRC_W(CRC_W)) vrd_i (
    .clk(clk), .rst_n(rst_n), .first_i(first), .eval_i(eval), .short_i(short_f),
    .ones_i(ones), .match_i(match), .group_i(group), .crc_i(crc_next),
    .bcast_reject_i(cfg_bcast_reject), .hash_all_i(cfg_hash_all),
    .promisc_i(cfg_promisc), .hash_lo_i(hash_lo), .hash_hi_i(hash_hi),
    .valid_o(res_valid), .accept_o(res_accept), .miss_o(res_miss));
endmodule

// File: tb/rx_dest_filter_tb.sv
module rx_dest_filter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready;
  logic cfg_bcast_reject = 1'b0, cfg_hash_all = 1'b0, cfg_promisc = 1'b0;
  logic [31:0] hash_lo = 32'hA5A5_0F0F, hash_hi = 32'h3C3C_F00F;
  logic [31:0] stn_addr_hi = 32'h0000_0211, stn_addr_lo = 32'h2233_4455;
  logic res_valid, res_accept, res_miss;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rx_dest_filter dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_last(in_last),
    .cfg_bcast_reject(cfg_bcast_reject), .cfg_hash_all(cfg_hash_all),
    .cfg_promisc(cfg_promisc), .hash_lo(hash_lo), .hash_hi(hash_hi),
    .stn_addr_hi(stn_addr_hi), .stn_addr_lo(stn_addr_lo),
    .res_valid(res_valid), .res_accept(res_accept), .res_miss(res_miss));

  typedef struct packed {
    logic [47:0] da;
    logic [3:0]  nb;
    logic        bcr;
    logic        ha;
    logic        pr;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{48'hFFFF_FFFF_FFFF, 4'd6, 1'b0, 1'b0, 1'b0, 4'd2},
    '{48'hFFFF_FFFF_FFFF, 4'd7, 1'b1, 1'b0, 1'b0, 4'd2},
    '{48'hFFFF_FFFF_FFFF, 4'd6, 1'b1, 1'b0, 1'b1, 4'd5},
    '{48'h0100_5E00_00FB, 4'd8, 1'b0, 1'b0, 1'b0, 4'd3},
    '{48'h3333_0000_0001, 4'd7, 1'b0, 1'b0, 1'b0, 4'd3},
    '{48'h0211_2233_4455, 4'd6, 1'b0, 1'b0, 1'b0, 4'd4},
    '{48'h0211_2233_4456, 4'd6, 1'b0, 1'b0, 1'b0, 4'd4},
    '{48'h0211_2233_4455, 4'd6, 1'b0, 1'b1, 1'b0, 4'd3},
    '{48'hFFFF_FFFF_FFFE, 4'd9, 1'b0, 1'b0, 1'b0, 4'd2},
    '{48'h0255_1122_3344, 4'd6, 1'b0, 1'b0, 1'b1, 4'd5},
    '{48'h0211_2233_4455, 4'd4, 1'b0, 1'b0, 1'b0, 4'd6},
    '{48'hFFFF_FFFF_FFFF, 4'd5, 1'b0, 1'b0, 1'b1, 4'd6}
  };

  function automatic logic [5:0] hash_index(input logic [47:0] da);
    logic [31:0] r;
    logic [7:0] b;
    r = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++) begin
      b = da[47 - 8*k -: 8];
      for (int j = 0; j < 8; j++) begin
        if (r[0] ^ b[j]) r = (r >> 1) ^ 32'hEDB8_8320;
        else             r = r >> 1;
      end
    end
    return {r[0], r[1], r[2], r[3], r[4], r[5]};
  endfunction

  // returns {miss, accept}
  function automatic logic [1:0] model(input logic [47:0] da, input int nb,
                                       input logic bcr, ha, pr);
    logic miss;
    logic [5:0] ix;
    if (nb < 6) miss = 1'b1;
    else if (da == 48'hFFFF_FFFF_FFFF) miss = bcr;
    else if (da[40] || ha) begin
      ix = hash_index(da);
      miss = (ix < 6'd32) ? !hash_lo[ix[4:0]] : !hash_hi[ix[4:0]];
    end else miss = (da != {stn_addr_hi[15:0], stn_addr_lo});
    return {miss, !miss || pr};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // called at a negedge; returns at a negedge after the frame
  task automatic send(input logic [47:0] da, input int nb, input int gap,
                      output bit tim_bad);
    tim_bad = 0;
    for (int i = 0; i < nb; i++) begin
      in_valid = 1'b1;
      in_sof   = (i == 0);
      in_last  = (i == nb - 1);
      in_data  = (i < 6) ? da[47 - 8*i -: 8] : 8'(8'hC0 + i);
      @(negedge clk);
      for (int g = 0; g < gap; g++) begin
        in_valid = 1'b0; in_sof = 1'b1; in_last = 1'b1; in_data = 8'h5A;
        @(negedge clk);
      end
      if (res_valid !== ((i + 1 >= 6) || (i == nb - 1))) tim_bad = 1;
    end
    in_valid = 1'b0; in_sof = 1'b0; in_last = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 20000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit tb;
    logic [1:0] e;
    logic [47:0] mc;
    logic [63:0] t;
    logic a0, m0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(res_valid == 0, "R1", "valid", 32'(res_valid), 0);
    chk(res_accept == 0 && res_miss == 0, "R1", "accept/miss",
        {30'd0, res_accept, res_miss}, 0);
    chk(in_ready == 1, "R1", "ready in reset", 32'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(res_valid == 0 && in_ready == 1, "R1", "after release",
        {30'd0, res_valid, in_ready}, 1);

    // vector walk
    foreach (VECS[v]) begin
      cfg_bcast_reject = VECS[v].bcr;
      cfg_hash_all     = VECS[v].ha;
      cfg_promisc      = VECS[v].pr;
      e = model(VECS[v].da, int'(VECS[v].nb), VECS[v].bcr, VECS[v].ha, VECS[v].pr);
      send(VECS[v].da, int'(VECS[v].nb), v % 3, tb);
      chk(res_valid && {res_miss, res_accept} == e, $sformatf("R%0d", VECS[v].req),
          $sformatf("vector %0d miss/accept", v), {30'd0, res_miss, res_accept}, {30'd0, e});
      chk(!tb, "R7", $sformatf("vector %0d valid timing", v), 32'(tb), 0);
    end

    // R3 targeted hash entries
    cfg_bcast_reject = 0; cfg_hash_all = 0; cfg_promisc = 0;
    for (int q = 0; q < 2; q++) begin
      mc = (q == 0) ? 48'h0100_5E7F_1234 : 48'h3333_0000_0002;
      t = 64'd1 << hash_index(mc);
      hash_lo = t[31:0]; hash_hi = t[63:32];
      send(mc, 6, 0, tb);
      chk(res_miss == 0 && res_accept == 1, "R3", "sole entry set",
          {30'd0, res_miss, res_accept}, 1);
      hash_lo = ~t[31:0]; hash_hi = ~t[63:32];
      send(mc, 6, 1, tb);
      chk(res_miss == 1 && res_accept == 0, "R3", "sole entry clear",
          {30'd0, res_miss, res_accept}, 2);
    end
    hash_lo = 32'hA5A5_0F0F; hash_hi = 32'h3C3C_F00F;

    // R8 hold under configuration change
    send(48'h0211_2233_4455, 6, 0, tb);
    a0 = res_accept; m0 = res_miss;
    chk(a0 == 1 && m0 == 0, "R4", "station hit", {30'd0, m0, a0}, 1);
    cfg_promisc = 1; cfg_bcast_reject = 1; cfg_hash_all = 1; stn_addr_lo = 32'h0;
    repeat (4) @(negedge clk);
    chk(res_valid && res_accept == a0 && res_miss == m0, "R8", "hold after cfg change",
        {29'd0, res_valid, res_miss, res_accept}, {29'd0, 1'b1, m0, a0});
    // R9 stray beats after the frame and sof without valid
    for (int s = 0; s < 3; s++) begin
      in_valid = 1; in_sof = 0; in_last = s[0]; in_data = 8'hFF;
      @(negedge clk);
    end
    in_valid = 0; in_sof = 1; @(negedge clk); @(negedge clk); in_sof = 0;
    chk(res_valid && res_accept == a0 && res_miss == m0, "R9", "stray beats ignored",
        {29'd0, res_valid, res_miss, res_accept}, {29'd0, 1'b1, m0, a0});
    cfg_promisc = 0; cfg_bcast_reject = 0; cfg_hash_all = 0; stn_addr_lo = 32'h2233_4455;
    // R8 sof clears valid
    in_valid = 1; in_sof = 1; in_last = 0; in_data = 8'hFF;
    @(negedge clk);
    in_valid = 0; in_sof = 0;
    chk(res_valid == 0, "R8", "sof clears valid", 32'(res_valid), 0);
    // R9 restart mid-frame
    for (int s = 0; s < 2; s++) begin
      in_valid = 1; in_data = 8'hFF; @(negedge clk);
    end
    in_valid = 0;
    cfg_bcast_reject = 1;
    send(48'h0211_2233_4455, 7, 0, tb);
    chk(res_miss == 0 && res_accept == 1, "R9", "restart at sof",
        {30'd0, res_miss, res_accept}, 1);
    cfg_bcast_reject = 0;

    // R6 one-byte frame
    in_valid = 1; in_sof = 1; in_last = 1; in_data = 8'h02;
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_last = 0;
    chk(res_valid && res_miss && !res_accept, "R6", "one-byte frame",
        {29'd0, res_valid, res_miss, res_accept}, 32'h6);

    // R7 bytes after the sixth do not change the verdict
    send(48'h0211_2233_4456, 9, 2, tb);
    chk(res_miss == 1 && !tb, "R7", "trailing bytes",
        {30'd0, res_miss, tb}, 2);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule